// File: doc/BRIEF.md
# SCSI Host Adapter Register Interface

This block is the byte-wide register front end of a SCSI host adapter. A processor bus reaches sixteen byte registers at word-spaced addresses; the block decodes each access, holds the status, interrupt, sequence-step, configuration and transfer-count registers, and runs the commands written to the command register. Commands that act on the register file alone (no-op, FIFO flush, chip reset, bus reset) complete inside the block. Commands that need the SCSI bus or the DMA engine (transfer, command-complete sequence, message accepted, set attention, the two selection commands) leave as one-cycle start strobes toward the sequencing logic.

When that sequencing logic finishes a phase, it reports back through an event port that loads status, interrupt and step values and raises a level interrupt request. Software clears the request by reading the interrupt register. A 32-byte FIFO behind register 2 buffers bytes written and read by the processor; register 7 reports how many bytes it holds.

Top module: `scsi_regif`

## Requirements
- R1: The register index is address bits [5:2]. Registers 8, 12, 13, 14 and 15 read back the last byte written to them. Register 14 resets to 0x04.
- R2: A write to register 11 stores only bits 4, 2 and 0 (mask 0x15).
- R3: Bus writes to registers 4, 5, 6, 7, 9 and 10 change nothing; 9 and 10 always read 0.
- R4: A write to register 3 stores the whole byte in the command register. Bit 7 of that byte sets dma_mode and copies the stored count bytes into the live count (registers 0 and 1 read the live count). With bit 7 clear, dma_mode goes low and the live count is kept.
- R5: Command 0x01 (flush) empties the FIFO, sets the interrupt register to 0x08 and the step register to 0, and leaves irq as it was.
- R6: Command 0x02 (chip reset) clears every register, including the command register and dma_mode, sets register 14 to 0x04, empties the FIFO and drops irq.
- R7: Command 0x03 (bus reset) sets the interrupt register to 0x80 and raises irq only when bit 6 of register 8 is 0.
- R8: Command 0x12 (message accepted) sets the interrupt register to 0x20 and the step register to 0, and raises irq.
- R9: Opcodes 0x10, 0x11, 0x12, 0x1A, 0x42 and 0x43 (bits [6:0]) pulse xfer_go, icc_go, msg_ok_go, atn_go, sel_go and sel_stop_go respectively for one cycle after the write. At most one strobe is high at a time. Other opcodes produce no strobe and change only the command register.
- R10: A read of register 5 returns its value, then clears it to 0, clears status bits 7, 6 and 5, and drops irq. The other status bits are kept.
- R11: evt_valid loads status (register 4), interrupt (register 5) and step (register 6, low 3 bits) and raises irq. irq then holds until register 5 is read or a chip reset.
- R12: Writes to register 2 push into the FIFO and reads pop it in order. Register 7 holds the byte count. A push when 32 bytes are held is dropped. A read from an empty FIFO returns 0.
- R13: A write to register 0 or 1 clears status bit 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 6 | Byte address; bits [5:2] pick the register |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; read side effects take place at the clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| evt_valid | input | 1 | Phase-done event from the sequencer |
| evt_status | input | 8 | Status value to load |
| evt_intr | input | 8 | Interrupt value to load |
| evt_step | input | 3 | Sequence-step value to load |
| irq | output | 1 | Level interrupt request |
| dma_mode | output | 1 | Last command asked for DMA |
| xfer_go | output | 1 | Start transfer information |
| icc_go | output | 1 | Start command-complete sequence |
| msg_ok_go | output | 1 | Start message accepted |
| atn_go | output | 1 | Assert attention |
| sel_go | output | 1 | Start select with attention |
| sel_stop_go | output | 1 | Start select with attention and stop |

## Verification
The bench goes after the read side effects. It checks that an interrupt-register read returns the value and only then clears it, so a design that cleared before returning would hand software a zero. It also checks that the read drops only the top three status bits; a design that cleared the whole status byte would lose the count-zero bit. It checks that the count reload depends on bit 7, since a design that reloaded on every command would corrupt the live count. It drives bus reset with configuration bit 6 both set and clear, checks that chip reset wipes the command register it was itself written to, fills the FIFO past full, and reads it while empty, where a wrong design would drop bytes or wrap its pointers.

// File: rtl/scsi_regif_pkg.sv
package scsi_regif_pkg;

  typedef enum logic [6:0] {
    OP_NOP      = 7'h00,
    OP_FLUSH    = 7'h01,
    OP_CHIPRST  = 7'h02,
    OP_BUSRST   = 7'h03,
    OP_XFER     = 7'h10,
    OP_ICC      = 7'h11,
    OP_MSGOK    = 7'h12,
    OP_ATN      = 7'h1A,
    OP_SEL      = 7'h42,
    OP_SELSTOP  = 7'h43
  } op_e;

  localparam logic [7:0] INT_FUNC_DONE  = 8'h08;
  localparam logic [7:0] INT_DISCONNECT = 8'h20;
  localparam logic [7:0] INT_BUS_RESET  = 8'h80;
  localparam logic [7:0] ST_READ_CLEAR  = 8'hE0;
  localparam logic [7:0] CFG11_KEEP     = 8'h15;
  localparam logic [7:0] ID_CODE        = 8'h04;

  localparam logic [3:0] IX_CNT_LO  = 4'd0;
  localparam logic [3:0] IX_CNT_HI  = 4'd1;
  localparam logic [3:0] IX_FIFO    = 4'd2;
  localparam logic [3:0] IX_CMD     = 4'd3;
  localparam logic [3:0] IX_STATUS  = 4'd4;
  localparam logic [3:0] IX_INTR    = 4'd5;
  localparam logic [3:0] IX_STEP    = 4'd6;
  localparam logic [3:0] IX_FLAGS   = 4'd7;
  localparam logic [3:0] IX_CFG8    = 4'd8;
  localparam logic [3:0] IX_CFG11   = 4'd11;
  localparam logic [3:0] IX_ID      = 4'd14;
  localparam int         SCRATCH_BASE = 12;
  localparam int         SCRATCH_NUM  = 4;

  typedef struct packed {
    logic xfer;
    logic icc;
    logic msg_ok;
    logic atn;
    logic sel;
    logic sel_stop;
  } go_t;

  // word-spaced map: the byte lanes below bit 2 do not select a register
  function automatic logic [3:0] reg_index(input logic [5:0] a);
    return a[5:2];
  endfunction

  function automatic logic [7:0] scratch_init(input logic [3:0] ix);
    return (ix == IX_ID) ? ID_CODE : 8'h00;
  endfunction

endpackage

// File: rtl/scsi_regif_fifo.sv
module scsi_regif_fifo #(
  parameter int DEPTH = 32,
  parameter int W     = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         clr,
  input  logic                         push,
  input  logic [W-1:0]                 din,
  input  logic                         pop,
  output logic [W-1:0]                 dout,
  output logic [$clog2(DEPTH+1)-1:0]   count
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          push_ok, pop_ok;

  function automatic logic [AW-1:0] step_ptr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign push_ok = push && (count != CW'(DEPTH));
  assign pop_ok  = pop && (count != '0);
  assign dout    = (count == '0) ? '0 : mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= step_ptr(wr_ptr);
      if (pop_ok)  rd_ptr <= step_ptr(rd_ptr);
      count <= count + CW'(push_ok) - CW'(pop_ok);
    end
  end
endmodule

// File: rtl/scsi_regif_cmd_dec.sv
module scsi_regif_cmd_dec
  import scsi_regif_pkg::*;
(
  input  logic       cmd_wr,
  input  logic [6:0] opcode,
  output go_t        go,
  output logic       do_flush,
  output logic       do_chip_rst,
  output logic       do_bus_rst
);
  always_comb begin
    go          = '0;
    do_flush    = 1'b0;
    do_chip_rst = 1'b0;
    do_bus_rst  = 1'b0;
    if (cmd_wr) begin
      case (op_e'(opcode))
        OP_FLUSH:   do_flush    = 1'b1;
        OP_CHIPRST: do_chip_rst = 1'b1;
        OP_BUSRST:  do_bus_rst  = 1'b1;
        OP_XFER:    go.xfer     = 1'b1;
        OP_ICC:     go.icc      = 1'b1;
        OP_MSGOK:   go.msg_ok   = 1'b1;
        OP_ATN:     go.atn      = 1'b1;
        OP_SEL:     go.sel      = 1'b1;
        OP_SELSTOP: go.sel_stop = 1'b1;
        default:    ;
      endcase
    end
  end
endmodule

// File: rtl/scsi_regif.sv
module scsi_regif
  import scsi_regif_pkg::*;
#(
  parameter int DEPTH  = 32,
  parameter int STEP_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [5:0]        bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              evt_valid,
  input  logic [7:0]        evt_status,
  input  logic [7:0]        evt_intr,
  input  logic [STEP_W-1:0] evt_step,
  output logic              irq,
  output logic              dma_mode,
  output logic              xfer_go,
  output logic              icc_go,
  output logic              msg_ok_go,
  output logic              atn_go,
  output logic              sel_go,
  output logic              sel_stop_go
);
  localparam int CW = $clog2(DEPTH + 1);

  // named internal events, also used by the checker
  logic [3:0]    idx;
  logic          cmd_wr, int_rd, fifo_push, fifo_pop, fifo_clr, raise_irq;
  logic          do_flush, do_chip_rst, do_bus_rst;
  go_t           go_d, go_q;
  logic [7:0]    fifo_dout;
  logic [CW-1:0] fifo_cnt;

  logic [7:0] cnt_live_lo, cnt_live_hi, cnt_set_lo, cnt_set_hi;
  logic [7:0] cmd_q, status_q, intr_q, step_q, cfg8_q, cfg11_q;
  logic       irq_q, dma_q;
  logic [8*SCRATCH_NUM-1:0] scratch_flat;

  assign idx       = reg_index(bus_addr);
  assign cmd_wr    = bus_wr && (idx == IX_CMD);
  assign int_rd    = bus_rd && (idx == IX_INTR);
  assign fifo_push = bus_wr && (idx == IX_FIFO);
  assign fifo_pop  = bus_rd && (idx == IX_FIFO);
  assign fifo_clr  = do_flush || do_chip_rst;
  assign raise_irq = evt_valid || go_d.msg_ok || (do_bus_rst && !cfg8_q[6]);

  scsi_regif_cmd_dec u_dec (
    .cmd_wr      (cmd_wr),
    .opcode      (bus_wdata[6:0]),
    .go          (go_d),
    .do_flush    (do_flush),
    .do_chip_rst (do_chip_rst),
    .do_bus_rst  (do_bus_rst)
  );

  scsi_regif_fifo #(.DEPTH(DEPTH), .W(8)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (fifo_clr),
    .push  (fifo_push),
    .din   (bus_wdata),
    .pop   (fifo_pop),
    .dout  (fifo_dout),
    .count (fifo_cnt)
  );

  // plain read/write scratch registers, one of which carries the ID code
  for (genvar g = 0; g < SCRATCH_NUM; g++) begin : g_scratch
    localparam logic [3:0] MY_IX = 4'(SCRATCH_BASE + g);
    logic [7:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        q <= scratch_init(MY_IX);
      else if (do_chip_rst)              q <= scratch_init(MY_IX);
      else if (bus_wr && idx == MY_IX)   q <= bus_wdata;
    end
    assign scratch_flat[g*8 +: 8] = q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_live_lo <= '0; cnt_live_hi <= '0; cnt_set_lo <= '0; cnt_set_hi <= '0;
      cmd_q <= '0; status_q <= '0; intr_q <= '0; step_q <= '0;
      cfg8_q <= '0; cfg11_q <= '0; irq_q <= 1'b0; dma_q <= 1'b0; go_q <= '0;
    end else if (do_chip_rst) begin
      cnt_live_lo <= '0; cnt_live_hi <= '0; cnt_set_lo <= '0; cnt_set_hi <= '0;
      cmd_q <= '0; status_q <= '0; intr_q <= '0; step_q <= '0;
      cfg8_q <= '0; cfg11_q <= '0; irq_q <= 1'b0; dma_q <= 1'b0; go_q <= '0;
    end else begin
      go_q <= go_d;
      // read side effect first, so a same-cycle event wins
      if (int_rd) begin
        intr_q   <= '0;
        status_q <= status_q & ~ST_READ_CLEAR;
      end
      if (evt_valid) begin
        status_q <= evt_status;
        intr_q   <= evt_intr;
        step_q   <= 8'(evt_step);
      end
      if (bus_wr) begin
        case (idx)
          IX_CNT_LO: begin cnt_set_lo <= bus_wdata; status_q[4] <= 1'b0; end
          IX_CNT_HI: begin cnt_set_hi <= bus_wdata; status_q[4] <= 1'b0; end
          IX_CFG8:   cfg8_q  <= bus_wdata;
          IX_CFG11:  cfg11_q <= bus_wdata & CFG11_KEEP;
          default:   ;
        endcase
      end
      if (cmd_wr) begin
        cmd_q <= bus_wdata;
        dma_q <= bus_wdata[7];
        if (bus_wdata[7]) begin
          cnt_live_lo <= cnt_set_lo;
          cnt_live_hi <= cnt_set_hi;
        end
      end
      if (do_flush) begin
        intr_q <= INT_FUNC_DONE;
        step_q <= '0;
      end
      if (do_bus_rst) intr_q <= INT_BUS_RESET;
      if (go_d.msg_ok) begin
        intr_q <= INT_DISCONNECT;
        step_q <= '0;
      end
      if (raise_irq)   irq_q <= 1'b1;
      else if (int_rd) irq_q <= 1'b0;
    end
  end

  always_comb begin
    case (idx)
      IX_CNT_LO: bus_rdata = cnt_live_lo;
      IX_CNT_HI: bus_rdata = cnt_live_hi;
      IX_FIFO:   bus_rdata = fifo_dout;
      IX_CMD:    bus_rdata = cmd_q;
      IX_STATUS: bus_rdata = status_q;
      IX_INTR:   bus_rdata = intr_q;
      IX_STEP:   bus_rdata = step_q;
      IX_FLAGS:  bus_rdata = 8'(fifo_cnt);
      IX_CFG8:   bus_rdata = cfg8_q;
      IX_CFG11:  bus_rdata = cfg11_q;
      4'd12, 4'd13, 4'd14, 4'd15: bus_rdata = scratch_flat[{idx[1:0], 3'b000} +: 8];
      default:   bus_rdata = 8'h00;
    endcase
  end

  assign irq         = irq_q;
  assign dma_mode    = dma_q;
  assign xfer_go     = go_q.xfer;
  assign icc_go      = go_q.icc;
  assign msg_ok_go   = go_q.msg_ok;
  assign atn_go      = go_q.atn;
  assign sel_go      = go_q.sel;
  assign sel_stop_go = go_q.sel_stop;
endmodule

// File: rtl/scsi_regif_chk.sv
module scsi_regif_chk
  import scsi_regif_pkg::*;
#(
  parameter int DEPTH = 32
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [3:0]                 idx,
  input logic                       wr,
  input logic                       rd,
  input logic [7:0]                 wdata,
  input logic                       evt_valid,
  input logic                       irq,
  input logic                       dma_mode,
  input logic [5:0]                 go,
  input logic [$clog2(DEPTH+1)-1:0] fifo_cnt
);
  logic cmd_w, chip_w, irq_rd;
  assign cmd_w  = wr && idx == IX_CMD;
  assign chip_w = cmd_w && wdata[6:0] == OP_CHIPRST;
  assign irq_rd = rd && !wr && idx == IX_INTR;

  AST_GO_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(go)); // R9
  AST_XFER_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    go[5] |-> $past(cmd_w && wdata[6:0] == OP_XFER)); // R9
  AST_SEL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    go[1] |-> $past(cmd_w && wdata[6:0] == OP_SEL)); // R9
  AST_DMA_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_w && !chip_w) |=> dma_mode == $past(wdata[7])); // R4
  AST_CHIP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    chip_w |=> (!irq && !dma_mode && fifo_cnt == '0)); // R6
  AST_IRQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_rd && !evt_valid) |=> !irq); // R10
  AST_EVT_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && !chip_w) |=> irq); // R11
  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !(rd && idx == IX_INTR) && !chip_w) |=> irq); // R11
  AST_FIFO_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_cnt <= ($clog2(DEPTH+1))'(DEPTH)); // R12
endmodule

bind scsi_regif scsi_regif_chk #(.DEPTH(DEPTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .idx       (idx),
  .wr        (bus_wr),
  .rd        (bus_rd),
  .wdata     (bus_wdata),
  .evt_valid (evt_valid),
  .irq       (irq),
  .dma_mode  (dma_mode),
  .go        ({xfer_go, icc_go, msg_ok_go, atn_go, sel_go, sel_stop_go}),
  .fifo_cnt  (fifo_cnt)
);

// File: tb/sim_scsi_regif.sv
module sim_scsi_regif;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] bus_addr = '0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       evt_valid = 1'b0;
  logic [7:0] evt_status = '0, evt_intr = '0;
  logic [2:0] evt_step = '0;
  logic       irq, dma_mode;
  logic       xfer_go, icc_go, msg_ok_go, atn_go, sel_go, sel_stop_go;

  int n_checks = 0, n_fail = 0;
  bit finished = 1'b0;
  logic [5:0] strobes_seen;

  always #5 clk = ~clk;

  scsi_regif u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_valid(evt_valid),
    .evt_status(evt_status), .evt_intr(evt_intr), .evt_step(evt_step),
    .irq(irq), .dma_mode(dma_mode), .xfer_go(xfer_go), .icc_go(icc_go),
    .msg_ok_go(msg_ok_go), .atn_go(atn_go), .sel_go(sel_go), .sel_stop_go(sel_stop_go)
  );

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] ix, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = {ix, 2'b00}; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
    strobes_seen = {xfer_go, icc_go, msg_ok_go, atn_go, sel_go, sel_stop_go};
  endtask

  task automatic rd(input logic [3:0] ix, output logic [7:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = {ix, 2'b00};
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic expect_reg(input string tag, input logic [3:0] ix, input logic [7:0] exp);
    logic [7:0] v;
    rd(ix, v);
    check(tag, v, exp);
  endtask

  task automatic evt(input logic [7:0] st, input logic [7:0] in, input logic [2:0] sq);
    @(negedge clk);
    evt_valid = 1'b1; evt_status = st; evt_intr = in; evt_step = sq;
    @(negedge clk);
    evt_valid = 1'b0;
  endtask

  task automatic t_reset;
    check("R6 irq after reset", {7'b0, irq}, 8'h00);
    check("R6 dma after reset", {7'b0, dma_mode}, 8'h00);
    expect_reg("R1 id code at reset", 4'd14, 8'h04);
    expect_reg("R6 intr at reset", 4'd5, 8'h00);
  endtask

  task automatic t_regs;
    wr(4'd8, 8'hA5);  expect_reg("R1 reg8", 4'd8, 8'hA5);
    wr(4'd12, 8'h3C); expect_reg("R1 reg12", 4'd12, 8'h3C);
    wr(4'd14, 8'h77); expect_reg("R1 reg14", 4'd14, 8'h77);
    wr(4'd15, 8'h81); expect_reg("R1 reg15", 4'd15, 8'h81);
    wr(4'd11, 8'hFF); expect_reg("R2 reg11 mask", 4'd11, 8'h15);
    wr(4'd4, 8'hFF);  expect_reg("R3 status ro", 4'd4, 8'h00);
    wr(4'd5, 8'hFF);  expect_reg("R3 intr ro", 4'd5, 8'h00);
    wr(4'd6, 8'hFF);  expect_reg("R3 step ro", 4'd6, 8'h00);
    wr(4'd7, 8'hFF);  expect_reg("R3 flags ro", 4'd7, 8'h00);
    wr(4'd9, 8'hFF);  expect_reg("R3 reg9", 4'd9, 8'h00);
    wr(4'd10, 8'hFF); expect_reg("R3 reg10", 4'd10, 8'h00);
  endtask

  task automatic t_count;
    wr(4'd0, 8'h34); wr(4'd1, 8'h12);
    expect_reg("R4 live lo before reload", 4'd0, 8'h00);
    wr(4'd3, 8'h00);
    check("R4 dma low on 0x00", {7'b0, dma_mode}, 8'h00);
    expect_reg("R4 no reload without bit7", 4'd1, 8'h00);
    wr(4'd3, 8'h80);
    check("R4 dma high on 0x80", {7'b0, dma_mode}, 8'h01);
    expect_reg("R4 reload lo", 4'd0, 8'h34);
    expect_reg("R4 reload hi", 4'd1, 8'h12);
    expect_reg("R4 cmd latched", 4'd3, 8'h80);
  endtask

  task automatic t_strobes;
    logic [6:0] ops [6] = '{7'h10, 7'h11, 7'h12, 7'h1A, 7'h42, 7'h43};
    for (int i = 0; i < 6; i++) begin
      wr(4'd3, {1'b0, ops[i]});
      check($sformatf("R9 strobe for %h", ops[i]), {2'b0, strobes_seen}, {2'b0, 6'b100000 >> i});
      @(negedge clk);
      check("R9 strobe one cycle", {2'b0, xfer_go, icc_go, msg_ok_go, atn_go, sel_go, sel_stop_go}, 8'h00);
    end
    evt(8'h00, 8'h00, 3'd0);
    expect_reg("R10 clear before unknown", 4'd5, 8'h00);
    wr(4'd3, 8'h55);
    check("R9 unknown no strobe", {2'b0, strobes_seen}, 8'h00);
    check("R9 unknown no irq", {7'b0, irq}, 8'h00);
    expect_reg("R9 unknown latched", 4'd3, 8'h55);
    expect_reg("R9 unknown intr kept", 4'd5, 8'h00);
  endtask

  task automatic t_event;
    evt(8'hF3, 8'h18, 3'd4);
    check("R11 irq on event", {7'b0, irq}, 8'h01);
    repeat (3) @(negedge clk);
    check("R11 irq held", {7'b0, irq}, 8'h01);
    expect_reg("R11 status loaded", 4'd4, 8'hF3);
    expect_reg("R11 step loaded", 4'd6, 8'h04);
    check("R11 irq held after reads", {7'b0, irq}, 8'h01);
    expect_reg("R10 intr read value", 4'd5, 8'h18);
    check("R10 irq dropped", {7'b0, irq}, 8'h00);
    expect_reg("R10 status partial clear", 4'd4, 8'h13);
    expect_reg("R10 intr cleared", 4'd5, 8'h00);
    wr(4'd0, 8'h01);
    expect_reg("R13 count write clears bit4", 4'd4, 8'h03);
  endtask

  task automatic t_busreset;
    wr(4'd8, 8'h00);
    wr(4'd3, 8'h03);
    check("R7 irq with cfg bit6 clear", {7'b0, irq}, 8'h01);
    expect_reg("R7 intr bus reset", 4'd5, 8'h80);
    wr(4'd8, 8'h40);
    wr(4'd3, 8'h03);
    check("R7 irq masked by cfg bit6", {7'b0, irq}, 8'h00);
    expect_reg("R7 intr masked case", 4'd5, 8'h80);
  endtask

  task automatic t_msgok;
    evt(8'h00, 8'h10, 3'd5);
    expect_reg("R11 intr for msg", 4'd5, 8'h10);
    wr(4'd3, 8'h12);
    check("R8 irq raised", {7'b0, irq}, 8'h01);
    expect_reg("R8 step zero", 4'd6, 8'h00);
    expect_reg("R8 intr disconnect", 4'd5, 8'h20);
  endtask

  task automatic t_fifo;
    logic [7:0] v;
    int bad;
    wr(4'd2, 8'h11); wr(4'd2, 8'h22); wr(4'd2, 8'h33);
    expect_reg("R12 count 3", 4'd7, 8'h03);
    expect_reg("R12 pop first", 4'd2, 8'h11);
    expect_reg("R12 pop second", 4'd2, 8'h22);
    expect_reg("R12 count 1", 4'd7, 8'h01);
    check("R5 irq low before flush", {7'b0, irq}, 8'h00);
    wr(4'd3, 8'h01);
    check("R5 flush keeps irq", {7'b0, irq}, 8'h00);
    expect_reg("R5 flush empties", 4'd7, 8'h00);
    expect_reg("R5 flush step", 4'd6, 8'h00);
    expect_reg("R5 flush intr", 4'd5, 8'h08);
    for (int i = 0; i < 33; i++) wr(4'd2, 8'(i + 1));
    expect_reg("R12 full count", 4'd7, 8'h20);
    bad = 0;
    for (int i = 0; i < 32; i++) begin
      rd(4'd2, v);
      if (v !== 8'(i + 1)) bad++;
    end
    check("R12 order over full fifo", 8'(bad), 8'h00);
    expect_reg("R12 empty read zero", 4'd2, 8'h00);
    expect_reg("R12 count after drain", 4'd7, 8'h00);
  endtask

  task automatic t_chiprst;
    wr(4'd8, 8'h5A); wr(4'd0, 8'h11); wr(4'd3, 8'h80); wr(4'd2, 8'h99);
    evt(8'hC0, 8'h18, 3'd2);
    wr(4'd3, 8'h82);
    check("R6 irq cleared", {7'b0, irq}, 8'h00);
    check("R6 dma cleared", {7'b0, dma_mode}, 8'h00);
    expect_reg("R6 cmd cleared", 4'd3, 8'h00);
    expect_reg("R6 cfg8 cleared", 4'd8, 8'h00);
    expect_reg("R6 id code", 4'd14, 8'h04);
    expect_reg("R6 status cleared", 4'd4, 8'h00);
    expect_reg("R6 fifo emptied", 4'd7, 8'h00);
    expect_reg("R6 count cleared", 4'd0, 8'h00);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_regs;
    t_count;
    t_strobes;
    t_event;
    t_busreset;
    t_msgok;
    t_fifo;
    t_chiprst;
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule